// File: doc/BRIEF.md
# MSI Write Address Router

The router sits between a simple memory request port and a bank of per-hart interrupt files. Each hart owns one machine-level file page and one supervisor-level file page, and the supervisor page is followed directly by a run of guest file pages. A message-signalled interrupt arrives as a 4-byte store into one of these pages. The router turns it into a single-cycle set-pending strobe that names the hart, the kind of file, the guest number and the interrupt identity carried in the write data.

The machine pages of all harts form one region: a base address and a per-hart stride. The supervisor and guest pages form a second region with its own base and stride. All of these, the page size, the hart count, the guest count and the identity count are parameters. Each aligned word inside a file page may be read, and the read returns zero. Within a page, the word at offset 0 accepts a little-endian identity and the word at offset 4 accepts a byte-reversed one. Every request gets a registered response one cycle later, with an error flag for accesses that are malformed or fall outside every file page.

Top module: `msi_addr_router`

## Requirements
- R1: Only size code 2'b10 (4 bytes) is accepted. Size codes 0, 1 and 3 get an error response and no strobe.
- R2: An address whose two low bits are not zero gets an error response and no strobe.
- R3: An aligned address in [M_BASE + h*M_STRIDE, M_BASE + h*M_STRIDE + PAGE_BYTES) targets hart h with kind code 0 (machine) and guest field 0.
- R4: An aligned address in the page at S_BASE + h*S_STRIDE targets hart h with kind code 1 (supervisor) and guest field 0.
- R5: An aligned address in the page at S_BASE + h*S_STRIDE + g*PAGE_BYTES, for 1 <= g <= GUESTS, targets hart h with kind code 2 (guest) and guest field g.
- R6: An address below a region base, at or beyond base + HARTS*stride, or inside a stride gap outside every file page, gets an error response and no strobe.
- R7: A 4-byte aligned read of any word in a file page gets a response without error, read data zero, and no strobe.
- R8: A write at page offset 0 uses the write data as the identity. A write at page offset 4 uses the write data with its four bytes reversed.
- R9: A write whose identity (after any reversal) is 0 or not below ID_COUNT is answered without error and raises no strobe.
- R10: A write to any aligned page offset other than 0 and 4 is answered without error and raises no strobe.
- R11: Each request cycle gives exactly one response in the next cycle, and no response otherwise. The strobe is raised only in a response cycle without error. After reset, no response and no strobe are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size as log2 of bytes (2'b10 = 4 bytes) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_err | output | 1 | Response carries an error |
| rsp_rdata | output | 32 | Read data (always zero) |
| sp_valid | output | 1 | Set-pending strobe |
| sp_hart | output | HART_W | Target hart index |
| sp_kind | output | 2 | File kind: 0 machine, 1 supervisor, 2 guest |
| sp_guest | output | GUEST_W | Guest number (0 unless the kind is guest) |
| sp_id | output | ID_W | Interrupt identity |

## Verification
The bench sweeps every hart through every page slot of both strides. It covers the pages past the last guest and the machine stride gap. A router that sized the guest window wrongly would accept a write into the gap, or reject the last guest page. The first and last word past each region edge are probed, so an off-by-one bound shows up as a missing error or a spurious one. Identity values of 0, ID_COUNT-1, ID_COUNT and values with high bits set are sent at both endian offsets. This catches a missing byte reversal, a range test on truncated bits, and a strobe raised for offsets other than 0 and 4.

// File: rtl/msi_route_pkg.sv
package msi_route_pkg;

    typedef enum logic [1:0] {
        FILE_MACH  = 2'd0,
        FILE_SUPV  = 2'd1,
        FILE_GUEST = 2'd2
    } file_kind_e;

    localparam logic [1:0] SIZE_WORD = 2'b10;
    localparam int LE_OFFSET = 0;
    localparam int BE_OFFSET = 4;

    typedef struct packed {
        logic valid;
        logic err;
    } rsp_t;

    function automatic logic [31:0] swap_bytes(input logic [31:0] w);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) begin
            r[8*b +: 8] = w[8*(3-b) +: 8];
        end
        return r;
    endfunction

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/msi_access_check.sv
module msi_access_check
    import msi_route_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic       ok
);
    assign ok = (size == SIZE_WORD) && (addr_lo == 2'b00);
endmodule

// File: rtl/msi_page_match.sv
module msi_page_match #(
    parameter int          ADDR_W  = 32,
    parameter int          HARTS   = 4,
    parameter int          HART_W  = 2,
    parameter logic [63:0] BASE    = 64'h0,
    parameter logic [63:0] STRIDE  = 64'h1000,
    parameter int          NPAGES  = 1,
    parameter int          PAGE_LG = 12,
    parameter int          PG_W    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [HART_W-1:0] hart,
    output logic [PG_W-1:0]   page
);
    localparam logic [63:0] SPAN = 64'(NPAGES) << PAGE_LG;

    logic [63:0]     a64;
    logic [HARTS-1:0] hit_v;
    logic [PG_W-1:0] pg_v [HARTS];

    assign a64 = 64'(addr);

    generate
        for (genvar h = 0; h < HARTS; h++) begin : g_hart
            localparam logic [63:0] LO = BASE + 64'(h) * STRIDE;
            logic [63:0] off;
            assign off      = a64 - LO;
            assign hit_v[h] = (a64 >= LO) && (off < SPAN);
            assign pg_v[h]  = PG_W'(off >> PAGE_LG);
        end
    endgenerate

    always_comb begin
        hit  = |hit_v;
        hart = '0;
        page = '0;
        for (int h = 0; h < HARTS; h++) begin
            if (hit_v[h]) begin
                hart = HART_W'(h);
                page = pg_v[h];
            end
        end
    end
endmodule

// File: rtl/msi_id_extract.sv
module msi_id_extract
    import msi_route_pkg::*;
#(
    parameter int ID_COUNT = 64,
    parameter int ID_W     = 6
) (
    input  logic [31:0]     wdata,
    input  logic            big_end,
    output logic [ID_W-1:0] id,
    output logic            id_ok
);
    logic [31:0] word;
    assign word  = big_end ? swap_bytes(wdata) : wdata;
    assign id_ok = (word != 32'd0) && (word < 32'(ID_COUNT));
    assign id    = word[ID_W-1:0];
endmodule

// File: rtl/msi_addr_router.sv
module msi_addr_router
    import msi_route_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          HARTS      = 4,
    parameter int          GUESTS     = 3,
    parameter int          PAGE_BYTES = 4096,
    parameter int          ID_COUNT   = 64,
    parameter logic [63:0] M_BASE     = 64'h1000_0000,
    parameter logic [63:0] M_STRIDE   = 64'h2000,
    parameter logic [63:0] S_BASE     = 64'h2000_0000,
    parameter logic [63:0] S_STRIDE   = 64'h8000,
    localparam int         HART_W     = width_of(HARTS),
    localparam int         GUEST_W    = width_of(GUESTS + 1),
    localparam int         ID_W       = width_of(ID_COUNT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [31:0]        rsp_rdata,
    output logic               sp_valid,
    output logic [HART_W-1:0]  sp_hart,
    output logic [1:0]         sp_kind,
    output logic [GUEST_W-1:0] sp_guest,
    output logic [ID_W-1:0]    sp_id
);
    localparam int PAGE_LG = $clog2(PAGE_BYTES);

    logic               acc_ok;
    logic               m_hit, s_hit;
    logic [HART_W-1:0]  m_hart, s_hart;
    logic [0:0]         m_page;
    logic [GUEST_W-1:0] s_page;
    logic [PAGE_LG-1:0] pg_off;
    logic               at_le, at_be;
    logic               file_hit, bad;
    logic [ID_W-1:0]    id_val;
    logic               id_ok, fire;
    file_kind_e         kind_n;
    logic [HART_W-1:0]  hart_n;
    logic [GUEST_W-1:0] guest_n;
    rsp_t               rsp_q;

    msi_access_check u_acc (
        .size    (req_size),
        .addr_lo (req_addr[1:0]),
        .ok      (acc_ok)
    );

    msi_page_match #(
        .ADDR_W (ADDR_W), .HARTS (HARTS), .HART_W (HART_W),
        .BASE (M_BASE), .STRIDE (M_STRIDE), .NPAGES (1),
        .PAGE_LG (PAGE_LG), .PG_W (1)
    ) u_mach (
        .addr (req_addr), .hit (m_hit), .hart (m_hart), .page (m_page)
    );

    msi_page_match #(
        .ADDR_W (ADDR_W), .HARTS (HARTS), .HART_W (HART_W),
        .BASE (S_BASE), .STRIDE (S_STRIDE), .NPAGES (GUESTS + 1),
        .PAGE_LG (PAGE_LG), .PG_W (GUEST_W)
    ) u_supv (
        .addr (req_addr), .hit (s_hit), .hart (s_hart), .page (s_page)
    );

    assign pg_off = req_addr[PAGE_LG-1:0];
    assign at_le  = (pg_off == PAGE_LG'(LE_OFFSET));
    assign at_be  = (pg_off == PAGE_LG'(BE_OFFSET));

    msi_id_extract #(
        .ID_COUNT (ID_COUNT), .ID_W (ID_W)
    ) u_id (
        .wdata (req_wdata), .big_end (at_be), .id (id_val), .id_ok (id_ok)
    );

    always_comb begin
        file_hit = (m_hit && (m_page == 1'b0)) || s_hit;
        bad      = !acc_ok || !file_hit;
        fire     = req_write && !bad && (at_le || at_be) && id_ok;
        if (m_hit) begin
            kind_n  = FILE_MACH;
            hart_n  = m_hart;
            guest_n = '0;
        end else if (s_page == '0) begin
            kind_n  = FILE_SUPV;
            hart_n  = s_hart;
            guest_n = '0;
        end else begin
            kind_n  = FILE_GUEST;
            hart_n  = s_hart;
            guest_n = s_page;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q    <= '0;
            sp_valid <= 1'b0;
            sp_hart  <= '0;
            sp_kind  <= FILE_MACH;
            sp_guest <= '0;
            sp_id    <= '0;
        end else begin
            rsp_q.valid <= req_valid;
            rsp_q.err   <= req_valid && bad;
            sp_valid    <= req_valid && fire;
            if (req_valid && fire) begin
                sp_hart  <= hart_n;
                sp_kind  <= kind_n;
                sp_guest <= guest_n;
                sp_id    <= id_val;
            end
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = '0;
endmodule

// File: rtl/msi_router_chk.sv
module msi_router_chk
    import msi_route_pkg::*;
#(
    parameter int GUEST_W = 2,
    parameter int ID_W    = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [1:0]         req_size,
    input logic [1:0]         addr_lo,
    input logic [31:0]        req_wdata,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic               sp_valid,
    input logic [1:0]         sp_kind,
    input logic [GUEST_W-1:0] sp_guest,
    input logic [ID_W-1:0]    sp_id
);
    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R11
    no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R11
    strobe_needs_clean_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        sp_valid |-> (rsp_valid && !rsp_err));
    // R1
    bad_size_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size != SIZE_WORD) |=> (rsp_err && !sp_valid));
    // R2
    misalign_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && addr_lo != 2'b00) |=> (rsp_err && !sp_valid));
    // R7
    read_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> !sp_valid);
    // R9
    zero_data_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_wdata == 32'd0) |=> !sp_valid);
    // R9
    strobe_id_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        sp_valid |-> (sp_id != '0));
    // R4
    guest_field_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_valid && sp_kind != FILE_GUEST) |-> (sp_guest == '0));
    // R5
    guest_field_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_valid && sp_kind == FILE_GUEST) |-> (sp_guest != '0));
endmodule

bind msi_addr_router msi_router_chk #(
    .GUEST_W (GUEST_W),
    .ID_W    (ID_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .addr_lo   (req_addr[1:0]),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .sp_valid  (sp_valid),
    .sp_kind   (sp_kind),
    .sp_guest  (sp_guest),
    .sp_id     (sp_id)
);

// File: tb/sim_msi_addr_router.sv
module sim_msi_addr_router;
    localparam int CLK_PERIOD = 10;
    localparam int HARTS  = 4;
    localparam int GUESTS = 3;
    localparam longint unsigned PAGE = 4096;
    localparam longint unsigned IDC  = 64;
    localparam longint unsigned MB = 64'h1000_0000;
    localparam longint unsigned MS = 64'h2000;
    localparam longint unsigned SB = 64'h2000_0000;
    localparam longint unsigned SS = 64'h8000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, sp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  sp_hart;
    logic [1:0]  sp_kind;
    logic [1:0]  sp_guest;
    logic [5:0]  sp_id;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_addr_router u0 (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_write (req_write), .req_size (req_size),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_err (rsp_err), .rsp_rdata (rsp_rdata),
        .sp_valid (sp_valid), .sp_hart (sp_hart), .sp_kind (sp_kind),
        .sp_guest (sp_guest), .sp_id (sp_id)
    );

    function automatic logic [31:0] rev(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    task automatic check(input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic access(input string tag, input bit wr, input logic [1:0] sz,
                          input longint unsigned a, input logic [31:0] d);
        bit e_err = 1'b1;
        bit e_sp = 1'b0;
        longint unsigned r = 0, h = 0, p = 0, kind = 0, gst = 0, v = 0, off;
        bit has_v = 1'b0;
        if (sz == 2'b10 && (a % 4) == 0) begin
            if (a >= MB && a < MB + HARTS * MS) begin
                r = a - MB; h = r / MS; p = (r % MS) / PAGE;
                if (p == 0) begin e_err = 1'b0; kind = 0; gst = 0; end
            end else if (a >= SB && a < SB + HARTS * SS) begin
                r = a - SB; h = r / SS; p = (r % SS) / PAGE;
                if (p <= GUESTS) begin
                    e_err = 1'b0; kind = (p == 0) ? 1 : 2; gst = p;
                end
            end
        end
        if (!e_err && wr) begin
            off = r % PAGE;
            if (off == 0) begin v = d; has_v = 1'b1; end
            else if (off == 4) begin v = rev(d); has_v = 1'b1; end
            if (has_v && v != 0 && v < IDC) e_sp = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = a[31:0]; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, "rsp_valid", rsp_valid, 1);
        check(tag, "rsp_err", rsp_err, e_err);
        check(tag, "sp_valid", sp_valid, e_sp);
        if (!wr) check(tag, "rsp_rdata", rsp_rdata, 0);
        if (e_sp) begin
            check(tag, "sp_hart", sp_hart, h);
            check(tag, "sp_kind", sp_kind, kind);
            check(tag, "sp_guest", sp_guest, gst);
            check(tag, "sp_id", sp_id, v);
        end
        @(negedge clk);
        check("R11", "idle rsp_valid", rsp_valid, 0);
        check("R11", "idle sp_valid", sp_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11", "reset rsp_valid", rsp_valid, 0);
        check("R11", "reset sp_valid", sp_valid, 0);
        check("R11", "reset rsp_err", rsp_err, 0);

        // R3 machine pages, R6 machine stride gap, R7 reads, R8 endianness, R10 other offsets
        for (int h = 0; h < HARTS; h++) begin
            for (int k = 0; k < 5; k++) begin
                longint unsigned offs [5] = '{0, 4, 8, PAGE, PAGE + 4};
                longint unsigned a = MB + h * MS + offs[k];
                logic [31:0] id = 32'(1 + (h * 5 + k) % 60);
                access("R3", 1'b1, 2'b10, a, (k == 1 || k == 4) ? rev(id) : id);
                access("R7", 1'b0, 2'b10, a, 32'h0);
            end
        end

        // R4 supervisor, R5 guests, R6 pages past last guest
        for (int h = 0; h < HARTS; h++) begin
            for (int p = 0; p < 8; p++) begin
                for (int k = 0; k < 3; k++) begin
                    longint unsigned offs [3] = '{0, 4, 16};
                    longint unsigned a = SB + h * SS + p * PAGE + offs[k];
                    logic [31:0] id = 32'(1 + (h * 11 + p * 7 + k) % 63);
                    string tg = (p == 0) ? "R4" : ((p <= GUESTS) ? "R5" : "R6");
                    access(tg, 1'b1, 2'b10, a, (k == 1) ? rev(id) : id);
                end
                access("R7", 1'b0, 2'b10, SB + h * SS + p * PAGE + 12, 32'h0);
            end
        end

        // R9 identity bounds at both offsets, R8 reversal
        access("R9", 1'b1, 2'b10, MB + MS, 32'd0);
        access("R9", 1'b1, 2'b10, MB + MS, 32'd63);
        access("R9", 1'b1, 2'b10, MB + MS, 32'd64);
        access("R9", 1'b1, 2'b10, MB + MS, 32'h0100_0001);
        access("R8", 1'b1, 2'b10, MB + MS + 4, 32'h3F00_0000);
        access("R8", 1'b1, 2'b10, MB + MS + 4, 32'h0000_003F);
        access("R8", 1'b1, 2'b10, SB + 2 * SS + 3 * PAGE + 4, 32'h0100_0000);
        access("R9", 1'b1, 2'b10, SB + 3 * SS + 4, 32'h0000_0000);

        // R1 sizes
        for (int s = 0; s < 4; s++) begin
            access("R1", 1'b1, 2'(s), SB + SS, 32'd5);
            access("R1", 1'b0, 2'(s), MB, 32'd0);
        end

        // R2 misalignment
        for (int m = 1; m < 4; m++) begin
            access("R2", 1'b1, 2'b10, MB + 2 * MS + m, 32'd9);
            access("R2", 1'b0, 2'b10, SB + PAGE + m, 32'd0);
        end

        // R6 region edges
        access("R6", 1'b1, 2'b10, MB - 4, 32'd3);
        access("R6", 1'b1, 2'b10, MB + HARTS * MS, 32'd3);
        access("R6", 1'b0, 2'b10, MB + (HARTS - 1) * MS + PAGE - 4, 32'd0);
        access("R6", 1'b1, 2'b10, SB - 4, 32'd3);
        access("R6", 1'b1, 2'b10, SB + HARTS * SS, 32'd3);
        access("R6", 1'b1, 2'b10, SB + (HARTS - 1) * SS + (GUESTS + 1) * PAGE, 32'd3);
        access("R6", 1'b1, 2'b10, 0, 32'd3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule